// File: doc/BRIEF.md
# Converter Start and Readback Sequencer

This block sits on the host side of a successive-approximation converter that starts a conversion with an active-low write strobe. Two status lines come back from the converter: a settling line and a converting line. A single-cycle start request carries a channel number, a mode bit and a readback level. In the first mode the channel is loaded into the converter's input multiplexer and a settling phase is expected. In the second mode the previously selected channel is kept and there is no settling phase.

Once a request is accepted, the block drives the channel and the mode level and holds them steady. It then produces a write-low pulse of at least the minimum width and follows the status lines until the conversion ends. After that it waits for the data hold-off time and issues a one-cycle done pulse, which tells the host that the serial data may be captured. The read strobe level is latched when the request is accepted and stays constant for the whole conversion.

Each wait state has a cycle limit. The limit is derived from the clock period, the worst-case timing and a margin. If a wait state overstays its limit, the block returns to idle and pulses a timeout flag. The clock period and every timing limit are parameters. The cycle counts are computed when the design is elaborated.

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `wr_n_o` is 1, `rd_n_o` is 1, `busy_o`, `done_o` and `timeout_o` are 0, and `mux_addr_o` and `addr_load_o` are 0.
- R2: When idle, a start request is accepted at a clock edge where the synchronized status lines are both low. At that edge `mux_addr_o` takes `chan_i`, `addr_load_o` takes `latch_sel_i` and `busy_o` rises. `wr_n_o` falls at the following edge.
- R3: `wr_n_o` stays low for exactly WR_CYC cycles, where WR_CYC = ceil(WR_MIN_NS*1000/CLK_PS). After that it stays high until the next accepted request.
- R4: `mux_addr_o` and `addr_load_o` do not change while `busy_o` is high.
- R5: With `addr_load_o`=1, the block moves on in three steps. First it waits for the synchronized settle line to be seen high at any point since the write strobe fell. Then it waits for the settle line to go low. Then it waits for the converting line, having been seen high, to go low.
- R6: With `addr_load_o`=0, the settle line is ignored. The block waits for the converting line to be seen high, then for it to go low.
- R7: `done_o` pulses for one cycle. The pulse comes at the DATA_CYC-th edge after the edge that saw the converting line low, where DATA_CYC = ceil(DATA_NS*1000/CLK_PS). `busy_o` falls at the same edge.
- R8: `rd_n_o` equals the inverse of `rd_hold_low_i` as sampled at acceptance, and it does not change until the next accepted request.
- R9: A start request while `busy_o` is high is ignored: no second write pulse is issued, and the channel does not change.
- R10: A start request while idle is refused if either synchronized status line is high. In that case `busy_o` stays low and no write pulse is issued.
- R11: The rise wait, the settle wait and the converting wait time out after RISE_TO, SETTLE_TO and CONV_TO cycles. Each limit is ceil(limit_ns*1000/CLK_PS) + MARGIN_CYC, counted from entry to that wait state. On a timeout `timeout_o` pulses for one cycle and `busy_o` falls at the same edge.
- R12: Both status inputs pass through SYNC_STAGES flip-flops before the sequencer uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| chan_i | input | CHAN_W | Channel for this request |
| latch_sel_i | input | 1 | 1: load new channel with settling; 0: keep previous channel |
| rd_hold_low_i | input | 1 | 1: hold read strobe low during conversion |
| settle_busy_i | input | 1 | Converter settling status line |
| conv_busy_i | input | 1 | Converter converting status line |
| mux_addr_o | output | CHAN_W | Channel address to converter |
| addr_load_o | output | 1 | Channel-load mode level to converter |
| wr_n_o | output | 1 | Active-low write/start strobe |
| rd_n_o | output | 1 | Active-low read strobe level |
| busy_o | output | 1 | Request in progress; new starts refused |
| done_o | output | 1 | One-cycle pulse: new data may be captured |
| timeout_o | output | 1 | One-cycle pulse: status line timed out |

## Verification
The bench uses an 8 ns clock and two synchronizer stages. With these values the write pulse is 10 cycles, the rise limit is 23 cycles and the hold-off is 7 cycles. The settle limit is shortened to 1 µs (129 cycles) and the converting limit to 2 µs (254 cycles). This keeps settle and converting overruns only a few hundred cycles long, so all three timeout paths can be driven in a short run next to normal conversions in both modes. The two-stage synchronizer makes the model account for input latency. It also makes the refusal of a start while the status lines are high depend on delayed, not live, line values.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WRLO,
      ST_RISE,
      ST_SETTLE,
      ST_CONV,
      ST_HOLD
   } hs_state_e;

   function automatic int ns_to_cyc(input int ns, input int clk_ps);
      return (ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

endpackage

// File: rtl/adc_hs_sync.sv
module adc_hs_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d_i;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q_o = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/adc_hs_cnt.sv
module adc_hs_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [W-1:0] last_i,
   output logic         hit_o
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr_i) cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

   assign hit_o = (cnt == last_i);
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl
   import adc_hs_pkg::*;
#(
   parameter int CHAN_W        = 3,
   parameter int CLK_PS        = 8000,
   parameter int WR_MIN_NS     = 80,
   parameter int RISE_MAX_NS   = 150,
   parameter int SETTLE_MAX_NS = 15000,
   parameter int CONV_MAX_NS   = 20000,
   parameter int DATA_NS       = 50,
   parameter int MARGIN_CYC    = 4,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CHAN_W-1:0] chan_i,
   input  logic              latch_sel_i,
   input  logic              rd_hold_low_i,
   input  logic              settle_busy_i,
   input  logic              conv_busy_i,
   output logic [CHAN_W-1:0] mux_addr_o,
   output logic              addr_load_o,
   output logic              wr_n_o,
   output logic              rd_n_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              timeout_o
);
   localparam int WR_CYC    = ns_to_cyc(WR_MIN_NS, CLK_PS);
   localparam int RISE_TO   = ns_to_cyc(RISE_MAX_NS, CLK_PS) + MARGIN_CYC;
   localparam int SETTLE_TO = ns_to_cyc(SETTLE_MAX_NS, CLK_PS) + MARGIN_CYC;
   localparam int CONV_TO   = ns_to_cyc(CONV_MAX_NS, CLK_PS) + MARGIN_CYC;
   localparam int DATA_CYC  = ns_to_cyc(DATA_NS, CLK_PS);
   localparam int MAX_A     = (WR_CYC > RISE_TO) ? WR_CYC : RISE_TO;
   localparam int MAX_B     = (SETTLE_TO > CONV_TO) ? SETTLE_TO : CONV_TO;
   localparam int MAX_AB    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_CYC   = (MAX_AB > DATA_CYC) ? MAX_AB : DATA_CYC;
   localparam int CNT_W     = $clog2(MAX_CYC + 1);

   generate
      if (CHAN_W < 1) begin : g_bad_chan
         $error("CHAN_W must be at least 1");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("CLK_PS must be positive");
      end
      if (WR_CYC < 1 || DATA_CYC < 1) begin : g_bad_min
         $error("write width and data hold-off must round to at least one cycle");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [1:0] lines_s;
   logic       stl_s, sts_s;

   adc_hs_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({settle_busy_i, conv_busy_i}),
      .q_o   (lines_s)
   );
   assign stl_s = lines_s[1];
   assign sts_s = lines_s[0];

   hs_state_e          state, nxt;
   logic               hit, fin_done, fin_err;
   logic [CNT_W-1:0]   last_cnt;
   logic               stl_seen, sts_seen;
   logic [CHAN_W-1:0]  addr_q;
   logic               mode_q, rd_q, wr_n_q, done_q, err_q;

   adc_hs_cnt #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (nxt != state),
      .last_i (last_cnt),
      .hit_o  (hit)
   );

   always_comb begin
      case (state)
         ST_WRLO:   last_cnt = CNT_W'(WR_CYC - 1);
         ST_RISE:   last_cnt = CNT_W'(RISE_TO - 1);
         ST_SETTLE: last_cnt = CNT_W'(SETTLE_TO - 1);
         ST_CONV:   last_cnt = CNT_W'(CONV_TO - 1);
         ST_HOLD:   last_cnt = CNT_W'(DATA_CYC - 1);
         default:   last_cnt = '0;
      endcase
   end

   always_comb begin
      nxt      = state;
      fin_done = 1'b0;
      fin_err  = 1'b0;
      case (state)
         ST_IDLE:  if (start_i && !stl_s && !sts_s) nxt = ST_SETUP;
         ST_SETUP: nxt = ST_WRLO;
         ST_WRLO:  if (hit) nxt = ST_RISE;
         ST_RISE: begin
            if (mode_q ? (stl_seen || stl_s) : (sts_seen || sts_s))
               nxt = mode_q ? ST_SETTLE : ST_CONV;
            else if (hit) begin
               nxt     = ST_IDLE;
               fin_err = 1'b1;
            end
         end
         ST_SETTLE: begin
            if (!stl_s) nxt = ST_CONV;
            else if (hit) begin
               nxt     = ST_IDLE;
               fin_err = 1'b1;
            end
         end
         ST_CONV: begin
            if (sts_seen && !sts_s) nxt = ST_HOLD;
            else if (hit) begin
               nxt     = ST_IDLE;
               fin_err = 1'b1;
            end
         end
         ST_HOLD: if (hit) begin
            nxt      = ST_IDLE;
            fin_done = 1'b1;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         addr_q   <= '0;
         mode_q   <= 1'b0;
         rd_q     <= 1'b0;
         wr_n_q   <= 1'b1;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         stl_seen <= 1'b0;
         sts_seen <= 1'b0;
      end else begin
         state  <= nxt;
         wr_n_q <= (nxt != ST_WRLO);
         done_q <= fin_done;
         err_q  <= fin_err;
         if (state == ST_IDLE && nxt == ST_SETUP) begin
            addr_q <= chan_i;
            mode_q <= latch_sel_i;
            rd_q   <= rd_hold_low_i;
         end
         if (state == ST_SETUP) begin
            stl_seen <= 1'b0;
            sts_seen <= 1'b0;
         end else if (state != ST_IDLE) begin
            stl_seen <= stl_seen | stl_s;
            sts_seen <= sts_seen | sts_s;
         end
      end
   end

   assign mux_addr_o  = addr_q;
   assign addr_load_o = mode_q;
   assign wr_n_o      = wr_n_q;
   assign rd_n_o      = ~rd_q;
   assign busy_o      = (state != ST_IDLE);
   assign done_o      = done_q;
   assign timeout_o   = err_q;

   assert_wr_inside_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_o |-> busy_o);
   assert_wr_falls_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n_o) |-> $past(busy_o));
   assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(mux_addr_o) && $stable(addr_load_o)));
   assert_rd_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(rd_n_o));
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (!busy_o && !timeout_o));
   assert_timeout_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);
   assert_timeout_ends_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_o) |-> (!busy_o && wr_n_o));
endmodule

// File: tb/adc_start_ctrl_test.sv
module adc_start_ctrl_test;
   localparam int CW     = 3;
   localparam int CLK_PS = 8000;
   localparam int WR_CYC = 10;
   localparam int RISE_TO = 23;
   localparam int SETTLE_TO = 129;
   localparam int CONV_TO = 254;
   localparam int DATA_CYC = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [CW-1:0] chan = '0;
   logic sel = 1'b0, rdl = 1'b0, stl = 1'b0, sts = 1'b0;
   logic [CW-1:0] addr;
   logic aload, wr_n, rd_n, busy, done, tmo;

   int compared = 0, mismatched = 0, cyc = 0;
   int wr_falls = 0, wr_width = 0, done_cnt = 0, tmo_cnt = 0;

   always #4 clk = ~clk;

   adc_start_ctrl #(
      .CHAN_W(CW), .CLK_PS(CLK_PS), .WR_MIN_NS(80), .RISE_MAX_NS(150),
      .SETTLE_MAX_NS(1000), .CONV_MAX_NS(2000), .DATA_NS(50),
      .MARGIN_CYC(4), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan),
      .latch_sel_i(sel), .rd_hold_low_i(rdl), .settle_busy_i(stl),
      .conv_busy_i(sts), .mux_addr_o(addr), .addr_load_o(aload),
      .wr_n_o(wr_n), .rd_n_o(rd_n), .busy_o(busy), .done_o(done),
      .timeout_o(tmo)
   );

   // behavioural reference: phase number and countdown
   int ph = 0, left = 0;
   logic m_wr_n = 1, m_done = 0, m_err = 0, m_rd_n = 1, m_sel = 0;
   logic [CW-1:0] m_addr = '0;
   logic fl_l = 0, fl_s = 0;
   logic [1:0] h_l = '0, h_s = '0;

   always @(posedge clk) begin
      logic s_l, s_s;
      if (!rst_n) begin
         ph = 0; left = 0; m_wr_n = 1; m_done = 0; m_err = 0; m_rd_n = 1;
         m_sel = 0; m_addr = '0; fl_l = 0; fl_s = 0; h_l = '0; h_s = '0;
      end else begin
         s_l = h_l[1]; s_s = h_s[1];
         m_done = 0; m_err = 0;
         if (ph >= 2) begin fl_l = fl_l | s_l; fl_s = fl_s | s_s; end
         case (ph)
            0: if (start && !s_l && !s_s) begin
                  ph = 1; m_addr = chan; m_sel = sel; m_rd_n = !rdl;
               end
            1: begin ph = 2; m_wr_n = 0; left = WR_CYC; fl_l = 0; fl_s = 0; end
            2: if (left == 1) begin m_wr_n = 1; ph = 3; left = RISE_TO; end
               else left--;
            3: if (m_sel ? fl_l : fl_s) begin
                  ph = m_sel ? 4 : 5; left = m_sel ? SETTLE_TO : CONV_TO;
               end else if (left == 1) begin ph = 0; m_err = 1; end
               else left--;
            4: if (!s_l) begin ph = 5; left = CONV_TO; end
               else if (left == 1) begin ph = 0; m_err = 1; end
               else left--;
            5: if (fl_s && !s_s) begin ph = 6; left = DATA_CYC; end
               else if (left == 1) begin ph = 0; m_err = 1; end
               else left--;
            6: if (left == 1) begin ph = 0; m_done = 1; end
               else left--;
            default: ph = 0;
         endcase
         h_l = {h_l[0], stl};
         h_s = {h_s[0], sts};
      end
   end

   task automatic cmp(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         cmp("R3 wr_n", wr_n, m_wr_n);
         cmp("R9 busy", busy, ph != 0);
         cmp("R7 done", done, m_done);
         cmp("R11 timeout", tmo, m_err);
         cmp("R8 rd_n", rd_n, m_rd_n);
         cmp("R4 addr", addr, m_addr);
         cmp("R5 addr_load", aload, m_sel);
         if (!wr_n) wr_width++;
         else if (wr_width != 0) begin
            cmp("R3 write width", wr_width, WR_CYC);
            wr_width = 0;
         end
         if (done) done_cnt++;
         if (tmo) tmo_cnt++;
      end
      if (cyc > 150000) begin
         mismatched++;
         $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   always @(negedge wr_n) if (rst_n) wr_falls++;

   task automatic pulse_start(input logic [CW-1:0] c, input logic m, input logic r);
      @(negedge clk); #1; start = 1; chan = c; sel = m; rdl = r;
      @(negedge clk); #1; start = 0; chan = ~c;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // one transaction; negative count means the line never rises or falls
   task automatic run(input logic [CW-1:0] c, input logic m, input logic r,
                      input int settle, input int conv, input bit poke);
      int f0, d0;
      f0 = wr_falls; d0 = done_cnt;
      pulse_start(c, m, r);
      @(negedge wr_n); repeat (3) @(negedge clk); #1;
      if (m && settle >= 0) begin stl = 1; sts = 1; end
      if (!m && conv >= 0) sts = 1;
      if (!m) stl = 1; // ignored in this mode, R6
      if (m && settle >= 0) begin repeat (settle) @(negedge clk); #1; stl = 0; end
      if (poke) pulse_start(~c, !m, !r); // R9
      if (conv >= 0) begin repeat (conv) @(negedge clk); #1; sts = 0; end
      if (!m) stl = 0;
      wait_idle();
      stl = 0; sts = 0;
      repeat (4) @(negedge clk);
      cmp("R9 single write pulse", wr_falls - f0, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      cmp("R1 wr_n reset", wr_n, 1);
      cmp("R1 rd_n reset", rd_n, 1);
      cmp("R1 busy reset", busy, 0);
      cmp("R1 addr reset", addr, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      // R2 R5 R7 R8: mode with settling, readback held low
      run(3'd5, 1, 1, 40, 80, 1);
      cmp("R7 done count", done_cnt, 1);
      cmp("R8 rd level kept", rd_n, 0);
      // R6: keep-channel mode, settle line toggled but ignored
      run(3'd2, 0, 0, 0, 60, 1);
      cmp("R7 done count", done_cnt, 2);
      cmp("R8 rd level kept", rd_n, 1);
      // R10: start refused while status line high
      @(negedge clk); #1; sts = 1;
      repeat (4) @(negedge clk);
      pulse_start(3'd7, 1, 0);
      repeat (5) @(negedge clk);
      cmp("R10 refused start", busy, 0);
      cmp("R10 channel unchanged", addr, 2);
      sts = 0; stl = 1;
      repeat (4) @(negedge clk);
      pulse_start(3'd6, 1, 0);
      repeat (5) @(negedge clk);
      cmp("R10 refused start", busy, 0);
      stl = 0;
      repeat (4) @(negedge clk);
      // R11: rise timeout (settle line never rises)
      run(3'd1, 1, 0, -1, -1, 0);
      cmp("R11 rise timeout", tmo_cnt, 1);
      // R11: settle overrun
      run(3'd4, 1, 1, 300, 10, 0);
      cmp("R11 settle timeout", tmo_cnt, 2);
      // R11: converting overrun in keep-channel mode
      run(3'd3, 0, 1, 0, 400, 0);
      cmp("R11 convert timeout", tmo_cnt, 3);
      // R11 R6: converting line never rises
      run(3'd0, 0, 0, 0, -1, 0);
      cmp("R11 no convert rise", tmo_cnt, 4);
      // R12 R5: short settling, back-to-back requests
      run(3'd6, 1, 0, 1, 5, 0);
      run(3'd7, 1, 1, 2, 1, 1);
      cmp("R7 done count", done_cnt, 4);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule